// File: doc/BRIEF.md
# Edge-Triggered Calendar Time-Stamp Capture

This block watches an external time-stamp pin for one chosen edge. When that edge arrives it copies the live calendar time and date into snapshot registers and raises a stamp flag. The time field includes the AM/PM indicator. The pin is asynchronous, so a two-flop synchronizer sits in front of the edge detector. An edge-select control picks the rising or the falling transition as the event. A master enable gates detection, and a separate interrupt enable gates the interrupt output.

Software acknowledges a capture by pulsing a write-one-to-clear input. A second event can arrive before that acknowledgement. In that case the block keeps the first snapshot and raises a separate overflow flag. The lost event is therefore recorded rather than quietly written over the first one. If a clear and a new event land on the same clock, the event takes precedence.

Top module: `tstamp_capture`

## Requirements
- R1: After the synchronous active-low reset, both flags, both snapshots and `irq` are 0. A pin level that is already present when reset is released produces no event.
- R2: With `cfg_falling`=0 only a 0-to-1 pin transition is an event. With `cfg_falling`=1 only a 1-to-0 transition is an event. The opposite transition has no effect on the flags.
- R3: While `cfg_enable`=0, no pin transition sets any flag or changes any snapshot.
- R4: A qualifying pin change, applied before rising clock edge k, sets `stamp_flag` at rising edge k+2. The flag is visible after the third rising edge.
- R5: An event that finds `stamp_flag` clear loads `snap_time` and `snap_date` with `live_time` and `live_date` bit for bit. Bit 20 of the time is the PM bit: 1 means PM, and 0 means AM or 24-hour format.
- R6: An event that finds `stamp_flag` set raises `ovf_flag` and leaves both snapshots unchanged.
- R7: A one-cycle 1 on `clr_stamp` clears `stamp_flag`, and a one-cycle 1 on `clr_ovf` clears `ovf_flag`. Each clear input acts only on its own flag.
- R8: When an event and `clr_stamp` occur on the same cycle, `stamp_flag` stays set. The event is treated as arriving while the flag was in its pre-clear state.
- R9: `irq` is 1 exactly when `cfg_irq_en`=1 and `stamp_flag`=1.
- R10: Each qualifying edge produces exactly one event. Holding the pin at its new level raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_pin | input | 1 | Asynchronous time-stamp pin |
| cfg_enable | input | 1 | Enables event detection |
| cfg_falling | input | 1 | 0 selects the rising edge, 1 selects the falling edge |
| cfg_irq_en | input | 1 | Interrupt enable |
| live_time | input | 21 | Running calendar time (bit 20 is PM) |
| live_date | input | 22 | Running calendar date |
| clr_stamp | input | 1 | Write-one-to-clear for the stamp flag |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| snap_time | output | 21 | Captured time |
| snap_date | output | 22 | Captured date |
| stamp_flag | output | 1 | Capture pending |
| ovf_flag | output | 1 | Event lost while a capture was pending |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches every cycle for the following:
- an internal event always leaves the stamp flag set;
- an event on a set flag always raises overflow;
- the snapshots never move while a capture is pending;
- a clear with no event always drops the flag;
- the interrupt stays low when it is disabled.

Other behaviours need the bench's scenarios, because they depend on pin history rather than on one cycle. These are edge polarity, the gating by enable, the exact three-edge latency, the bit-exact content of the snapshot (including the PM bit), and the absence of a spurious event at reset release or while the pin is held.

// File: rtl/tstamp_pkg.sv
// Package: shared widths and field positions for the time-stamp capture block.
// Assumes the calendar packs its fields into flat vectors with PM on the top time bit.
package tstamp_pkg;
    localparam int TIME_W = 21;
    localparam int DATE_W = 22;
    localparam int PM_BIT = TIME_W - 1;
endpackage

// File: rtl/tstamp_edge_det.sv
// Synchronizes the asynchronous pin and turns one chosen transition into a single-cycle event.
// Assumes SYNC_STAGES >= 2; the history is qualified after reset so a static level is not an edge.
module tstamp_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic enable,
    input  logic falling,
    output logic event_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain;
    logic [CHAIN-1:0] warm;
    logic             now_lvl;
    logic             prev_lvl;
    logic             rise_seen;
    logic             fall_seen;

    // Synchronizer stages followed by one history flop.
    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Marks when every stage holds a real pin sample, not a reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= '0;
        else        warm <= {warm[CHAIN-2:0], 1'b1};
    end

    // Compares synchronized level with its history to find transitions.
    always_comb begin
        now_lvl   = chain[SYNC_STAGES-1];
        prev_lvl  = chain[SYNC_STAGES];
        rise_seen = now_lvl & ~prev_lvl;
        fall_seen = ~now_lvl & prev_lvl;
        event_o   = enable & warm[CHAIN-1] & (falling ? fall_seen : rise_seen);
    end
endmodule

// File: rtl/tstamp_flag_ctl.sv
// Holds the stamp and overflow flags and decides when the snapshot may load.
// Assumes event_i is a single-cycle pulse; an event outranks a clear on the same cycle.
module tstamp_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clr_stamp,
    input  logic clr_ovf,
    output logic stamp_flag,
    output logic ovf_flag,
    output logic load_snap
);
    // Only the first event of an unacknowledged series may load the snapshot.
    always_comb load_snap = event_i & ~stamp_flag;

    // Stamp flag: set by event, else cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         stamp_flag <= 1'b0;
        else if (event_i)   stamp_flag <= 1'b1;
        else if (clr_stamp) stamp_flag <= 1'b0;
    end

    // Overflow flag: set by an event on a pending capture, else cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovf_flag <= 1'b0;
        else if (event_i && stamp_flag)   ovf_flag <= 1'b1;
        else if (clr_ovf)                 ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/tstamp_snap_reg.sv
// Load-enabled snapshot register of parameter width.
// Assumes load is a single-cycle strobe; contents hold otherwise.
module tstamp_snap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Captures d on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/tstamp_capture.sv
// Top: edge-triggered capture of calendar time and date with overflow tracking.
// Assumes live_time/live_date are stable in the clock domain of clk.
module tstamp_capture #(
    parameter int SYNC_STAGES = 2,
    parameter int TIME_W      = tstamp_pkg::TIME_W,
    parameter int DATE_W      = tstamp_pkg::DATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_pin,
    input  logic              cfg_enable,
    input  logic              cfg_falling,
    input  logic              cfg_irq_en,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic              clr_stamp,
    input  logic              clr_ovf,
    output logic [TIME_W-1:0] snap_time,
    output logic [DATE_W-1:0] snap_date,
    output logic              stamp_flag,
    output logic              ovf_flag,
    output logic              irq
);
    logic ev_pulse;
    logic load_snap;

    tstamp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ts_pin),
        .enable    (cfg_enable),
        .falling   (cfg_falling),
        .event_o   (ev_pulse)
    );

    tstamp_flag_ctl u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (ev_pulse),
        .clr_stamp  (clr_stamp),
        .clr_ovf    (clr_ovf),
        .stamp_flag (stamp_flag),
        .ovf_flag   (ovf_flag),
        .load_snap  (load_snap)
    );

    tstamp_snap_reg #(.W(TIME_W)) u_snap_time (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_snap),
        .d     (live_time),
        .q     (snap_time)
    );

    tstamp_snap_reg #(.W(DATE_W)) u_snap_date (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_snap),
        .d     (live_date),
        .q     (snap_date)
    );

    // Interrupt request gated by its enable.
    always_comb irq = cfg_irq_en & stamp_flag;
endmodule

// File: rtl/tstamp_capture_chk.sv
// Checker: cycle-level properties of the time-stamp capture block, bound to the top.
// Assumes the internal event pulse is visible as ev_pulse in the top.
module tstamp_capture_chk #(
    parameter int TIME_W = 21,
    parameter int DATE_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_irq_en,
    input logic              clr_stamp,
    input logic              ev_pulse,
    input logic              stamp_flag,
    input logic              ovf_flag,
    input logic              irq,
    input logic [TIME_W-1:0] snap_time,
    input logic [DATE_W-1:0] snap_date
);
    assert_flag_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse |=> stamp_flag);

    assert_ovf_on_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse && stamp_flag) |=> ovf_flag);

    assert_ovf_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(stamp_flag));

    assert_snap_time_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_flag |=> $stable(snap_time));

    assert_snap_date_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_flag |=> $stable(snap_date));

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stamp && !ev_pulse) |=> !stamp_flag);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stamp && ev_pulse) |=> stamp_flag);

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !stamp_flag && !clr_stamp) |=> !stamp_flag);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);
endmodule

bind tstamp_capture tstamp_capture_chk #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_irq_en (cfg_irq_en),
    .clr_stamp  (clr_stamp),
    .ev_pulse   (ev_pulse),
    .stamp_flag (stamp_flag),
    .ovf_flag   (ovf_flag),
    .irq        (irq),
    .snap_time  (snap_time),
    .snap_date  (snap_date)
);

// File: tb/tstamp_capture_tb.sv
module tstamp_capture_tb;
    localparam int TW = 21;
    localparam int DW = 22;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ts_pin, cfg_enable, cfg_falling, cfg_irq_en;
    logic [TW-1:0] live_time;
    logic [DW-1:0] live_date;
    logic          clr_stamp, clr_ovf;
    logic [TW-1:0] snap_time;
    logic [DW-1:0] snap_date;
    logic          stamp_flag, ovf_flag, irq;

    int n_run  = 0;
    int n_fail = 0;

    logic          exp_stamp, exp_ovf;
    logic [TW-1:0] exp_time;
    logic [DW-1:0] exp_date;

    always #2 clk = ~clk;

    tstamp_capture u_dut (
        .clk(clk), .rst_n(rst_n), .ts_pin(ts_pin), .cfg_enable(cfg_enable),
        .cfg_falling(cfg_falling), .cfg_irq_en(cfg_irq_en), .live_time(live_time),
        .live_date(live_date), .clr_stamp(clr_stamp), .clr_ovf(clr_ovf),
        .snap_time(snap_time), .snap_date(snap_date), .stamp_flag(stamp_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    // Expected event for a pin transition under the current controls (R2, R3).
    function automatic logic exp_event(logic en, logic fall, logic old_lvl, logic new_lvl);
        if (!en || old_lvl == new_lvl) return 1'b0;
        return fall ? (old_lvl && !new_lvl) : (!old_lvl && new_lvl);
    endfunction

    // Expected interrupt (R9).
    function automatic logic exp_irq(logic en, logic st);
        return en & st;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " stamp"}, 64'(stamp_flag), 64'(exp_stamp));
        check({req, " ovf"},   64'(ovf_flag),   64'(exp_ovf));
        check({req, " time"},  64'(snap_time),  64'(exp_time));
        check({req, " date"},  64'(snap_date),  64'(exp_date));
        check({req, " irq"},   64'(irq),        64'(exp_irq(cfg_irq_en, exp_stamp)));
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Drives a pin level; optional clr_stamp on the cycle the event lands (R4, R8).
    task automatic drive_pin(logic new_lvl, logic clr_same, string req);
        logic ev;
        ev = exp_event(cfg_enable, cfg_falling, ts_pin, new_lvl);
        ts_pin = new_lvl;
        step(2);
        clr_stamp = clr_same;
        step(1);
        clr_stamp = 1'b0;
        if (ev) begin
            if (exp_stamp) exp_ovf = 1'b1;
            else begin
                exp_time = live_time;
                exp_date = live_date;
            end
            exp_stamp = 1'b1;
        end else if (clr_same) begin
            exp_stamp = 1'b0;
        end
        check_all(req);
    endtask

    task automatic do_clear(logic cs, logic co, string req);
        clr_stamp = cs;
        clr_ovf   = co;
        step(1);
        clr_stamp = 1'b0;
        clr_ovf   = 1'b0;
        if (cs) exp_stamp = 1'b0;
        if (co) exp_ovf   = 1'b0;
        check_all(req);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; ts_pin = 1'b1; cfg_enable = 1'b1; cfg_falling = 1'b0;
        cfg_irq_en = 1'b1; clr_stamp = 1'b0; clr_ovf = 1'b0;
        live_time = '0; live_date = '0;
        exp_stamp = 1'b0; exp_ovf = 1'b0; exp_time = '0; exp_date = '0;
        step(3);
        check_all("R1 reset");
        rst_n = 1'b1;
        step(6);
        check_all("R1 no event from level at reset");

        // Falling transition while rising selected: no event (R2).
        drive_pin(1'b0, 1'b0, "R2 opposite edge");

        // Rising edge capture with PM set (R4, R5).
        live_time = 21'h1A_BC5E | (21'h1 << 20);
        live_date = 22'h2A_5A5A;
        drive_pin(1'b1, 1'b0, "R5 capture PM");
        check("R5 PM bit", 64'(snap_time[20]), 64'd1);

        // Held level: no second event (R10).
        live_time = 21'h0_1234;
        step(8);
        check_all("R10 held level");

        // Overflow keeps first snapshot (R6).
        drive_pin(1'b0, 1'b0, "R6 falling ignored");
        live_time = 21'h05_5555;
        drive_pin(1'b1, 1'b0, "R6 overflow");

        // Clear each flag separately (R7).
        do_clear(1'b0, 1'b1, "R7 clear ovf only");
        do_clear(1'b1, 1'b0, "R7 clear stamp only");

        // Disabled: no event (R3).
        cfg_enable = 1'b0;
        drive_pin(1'b0, 1'b0, "R3 disabled");
        drive_pin(1'b1, 1'b0, "R3 disabled");
        cfg_enable = 1'b1;

        // Falling mode, AM time (R2, R5).
        cfg_falling = 1'b1;
        live_time = 21'h0F_0F0F;
        live_date = 22'h11_2233;
        drive_pin(1'b0, 1'b0, "R2 falling mode");
        check("R5 AM bit", 64'(snap_time[20]), 64'd0);

        // Same-cycle clear and event, flag set before (R8).
        drive_pin(1'b1, 1'b0, "R2 rising ignored in falling mode");
        drive_pin(1'b0, 1'b1, "R8 event beats clear pending");
        do_clear(1'b1, 1'b1, "R7 clear both");

        // Same-cycle clear and event, flag clear before (R8).
        drive_pin(1'b1, 1'b0, "R2 rising ignored");
        live_time = 21'h12_3456;
        drive_pin(1'b0, 1'b1, "R8 event beats clear fresh");

        // Interrupt gating (R9).
        cfg_irq_en = 1'b0;
        step(1);
        check("R9 irq off", 64'(irq), 64'd0);
        cfg_irq_en = 1'b1;
        step(1);
        check("R9 irq on", 64'(irq), 64'(exp_irq(1'b1, exp_stamp)));

        // Constrained random mix (R2 to R10).
        for (int it = 0; it < 120; it++) begin
            int act;
            act = int'($urandom_range(0, 5));
            live_time   = TW'($urandom);
            live_date   = DW'($urandom);
            cfg_irq_en  = 1'($urandom);
            if (act == 0) cfg_enable  = ($urandom_range(0, 3) != 0);
            if (act == 1) cfg_falling = 1'($urandom);
            if (act <= 3) drive_pin(~ts_pin, (act == 3) ? 1'($urandom) : 1'b0, "R4 random edge");
            else if (act == 4) do_clear(1'($urandom), 1'($urandom), "R7 random clear");
            else begin
                step(2);
                check_all("R10 random idle");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule